// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Line Remapper

This block sits between a requester and a line-addressed memory with a limited write endurance. The memory holds `LINES + 1` physical lines while the requester sees only `LINES` logical lines. Every logical line address is turned into a physical one by arithmetic on two small registers: a rotation offset and the position of the single empty physical slot. No per-line write counters and no mapping table are kept.

The block counts accepted writes. After every `PSI` of them, it runs one relocation step that copies the line just below the empty slot into the slot. The empty slot then sits one place lower. Once the slot has passed over every physical line, every logical line has moved by exactly one position and the rotation offset advances. Lines therefore wander through the array on a schedule set only by total write traffic, so a heavily written logical line does not stay on one physical line. During the two-cycle relocation the request side is stalled.

The memory port expects a synchronous array: a read issued in one cycle returns its data on `mem_rdata` in the next cycle. Read data for the requester comes back one cycle after acceptance, flagged by `rsp_valid`.

Top module: `sg_wear_leveler`

## Requirements
- R1: Directly after reset, the rotation offset is 0 and the empty slot is physical line `LINES`. Logical line k therefore maps to physical line k, `req_ready` is 1, and `rsp_valid` is 0.
- R2: An accepted request drives `mem_en`=1, `mem_we`=`req_write` and `mem_wdata`=`req_wdata` in the same cycle. `mem_addr` is computed as follows: p = (LA + offset) mod `LINES`, and if p ≥ slot then p + 1, otherwise p.
- R3: The physical address of an accepted request never equals the current empty-slot position.
- R4: Only accepted writes count; reads never count. The cycle after the `PSI`-th counted write begins a relocation, and the count restarts from zero.
- R5: A relocation is two cycles long. In the first cycle it reads physical line slot−1, or line `LINES` when the slot is 0. In the second cycle it writes the returned `mem_rdata` to physical line slot.
- R6: `req_ready` is 0 in both relocation cycles. A request held during them is not performed, and `req_ready` returns to 1 in the cycle after the write.
- R7: After each relocation the slot decreases by one. When the slot was 0, it is reloaded with `LINES` and the offset advances by one modulo `LINES`. At no other time do the slot or the offset change.
- R8: A read of logical line k returns the data most recently written to k, across any number of relocations and complete offset rotations.
- R9: `rsp_valid` is 1 exactly in the cycle after an accepted read, and `rsp_rdata` then carries that read's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | LA_W | Logical line address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PA_W | Physical line address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |

## Verification
A requester access and a relocation step can both want the memory port in the same cycle. This happens whenever a request is already waiting when the `PSI`-th write completes. The bench provokes it after every relocation trigger by holding a write to a logical line valid through both relocation cycles. It then requires that the port carries only the relocation read and write, with `req_ready` low, and that a later read of that line still returns its earlier value. It also checks that the first request after the step uses the shifted mapping.

// File: rtl/sg_pkg.sv
package sg_pkg;

   typedef enum logic {
      SG_SERVE = 1'b0,
      SG_COPY  = 1'b1
   } sg_state_e;

   function automatic bit sg_is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/sg_write_counter.sv
module sg_write_counter #(
   parameter int PSI = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic clear,
   output logic due
);
   localparam int CNT_W = (PSI > 1) ? $clog2(PSI + 1) : 1;
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PSI);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign due = (cnt_q == LIMIT);

endmodule

// File: rtl/sg_gap_regs.sv
module sg_gap_regs #(
   parameter int LINES = 8,
   localparam int LA_W = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int PA_W = $clog2(LINES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   output logic [LA_W-1:0] start_o,
   output logic [PA_W-1:0] gap_o,
   output logic [PA_W-1:0] src_o
);
   localparam logic [PA_W-1:0] TOP_SLOT = PA_W'(LINES);

   logic [LA_W-1:0] start_q;
   logic [PA_W-1:0] gap_q;
   logic [LA_W-1:0] start_next;
   logic            wrap;

   assign wrap = (gap_q == '0);

   generate
      if (sg_pkg::sg_is_pow2(LINES)) begin : g_start_pow2
         assign start_next = start_q + 1'b1;
      end else begin : g_start_mod
         assign start_next = (start_q == LA_W'(LINES - 1)) ? '0 : start_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         gap_q   <= TOP_SLOT;
      end else if (advance) begin
         if (wrap) begin
            gap_q   <= TOP_SLOT;
            start_q <= start_next;
         end else begin
            gap_q <= gap_q - 1'b1;
         end
      end
   end

   assign start_o = start_q;
   assign gap_o   = gap_q;
   assign src_o   = wrap ? TOP_SLOT : gap_q - 1'b1;

endmodule

// File: rtl/sg_translate.sv
module sg_translate #(
   parameter int LINES = 8,
   localparam int LA_W = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int PA_W = $clog2(LINES + 1)
) (
   input  logic [LA_W-1:0] la,
   input  logic [LA_W-1:0] start,
   input  logic [PA_W-1:0] gap,
   output logic [PA_W-1:0] pa
);
   logic [PA_W-1:0] rotated;

   generate
      if (sg_pkg::sg_is_pow2(LINES)) begin : g_rot_pow2
         logic [LA_W-1:0] low_sum;
         assign low_sum = la + start;
         assign rotated = PA_W'(low_sum);
      end else begin : g_rot_mod
         logic [PA_W:0] full_sum;
         assign full_sum = (PA_W + 1)'(la) + (PA_W + 1)'(start);
         assign rotated  = (full_sum >= (PA_W + 1)'(LINES))
                           ? PA_W'(full_sum - (PA_W + 1)'(LINES))
                           : PA_W'(full_sum);
      end
   endgenerate

   assign pa = (rotated >= gap) ? rotated + PA_W'(1) : rotated;

endmodule

// File: rtl/sg_wear_leveler.sv
module sg_wear_leveler
   import sg_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int PSI    = 100,
   parameter int DATA_W = 32,
   localparam int LA_W  = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int PA_W  = $clog2(LINES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LA_W-1:0]   req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (LINES < 2) begin : g_bad_lines
         $error("sg_wear_leveler: LINES must be at least 2");
      end
      if (PSI < 1) begin : g_bad_psi
         $error("sg_wear_leveler: PSI must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sg_wear_leveler: DATA_W must be at least 1");
      end
   endgenerate

   sg_state_e       state_q, state_d;
   logic            move_due;
   logic            in_copy;
   logic            fire;
   logic            start_move;
   logic [LA_W-1:0] start_cur;
   logic [PA_W-1:0] gap_cur;
   logic [PA_W-1:0] src_addr;
   logic [PA_W-1:0] req_pa;
   logic            rsp_q;

   assign in_copy    = (state_q == SG_COPY);
   assign start_move = (state_q == SG_SERVE) && move_due;
   assign req_ready  = (state_q == SG_SERVE) && !move_due;
   assign fire       = req_valid && req_ready;

   sg_write_counter #(.PSI(PSI)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fire && req_write),
      .clear (start_move),
      .due   (move_due)
   );

   sg_gap_regs #(.LINES(LINES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (in_copy),
      .start_o (start_cur),
      .gap_o   (gap_cur),
      .src_o   (src_addr)
   );

   sg_translate #(.LINES(LINES)) u_map (
      .la    (req_addr),
      .start (start_cur),
      .gap   (gap_cur),
      .pa    (req_pa)
   );

   always_comb begin
      state_d   = state_q;
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = req_pa;
      mem_wdata = req_wdata;
      unique case (state_q)
         SG_SERVE: begin
            if (move_due) begin
               mem_en   = 1'b1;
               mem_addr = src_addr;
               state_d  = SG_COPY;
            end else if (req_valid) begin
               mem_en = 1'b1;
               mem_we = req_write;
            end
         end
         SG_COPY: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = gap_cur;
            mem_wdata = mem_rdata;
            state_d   = SG_SERVE;
         end
         default: state_d = SG_SERVE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SG_SERVE;
         rsp_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         rsp_q   <= fire && !req_write;
      end
   end

   assign rsp_valid = rsp_q;
   assign rsp_rdata = mem_rdata;

endmodule

// File: rtl/sg_wear_leveler_chk.sv
module sg_wear_leveler_chk #(
   parameter int LINES = 8,
   localparam int LA_W = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int PA_W = $clog2(LINES + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            mem_en,
   input logic            mem_we,
   input logic [PA_W-1:0] mem_addr,
   input logic [PA_W-1:0] gap,
   input logic [LA_W-1:0] start,
   input logic            move_due,
   input logic            in_copy
);
   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= PA_W'(LINES)); // R7
   AST_START_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      start < LA_W'(LINES - 1) || start == LA_W'(LINES - 1)); // R7
   AST_PA_SKIPS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (mem_addr != gap)); // R3
   AST_STALL_IN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      in_copy |-> !req_ready); // R6
   AST_MOVE_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (move_due && !in_copy) |=> (in_copy && mem_en && mem_we && mem_addr == $past(gap))); // R5
   AST_GAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_copy && gap != '0) |=> (gap == $past(gap) - 1'b1 && $stable(start))); // R7
   AST_GAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_copy && gap == '0) |=> (gap == PA_W'(LINES))); // R7
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_copy |=> ($stable(gap) && $stable(start))); // R7
endmodule

bind sg_wear_leveler sg_wear_leveler_chk #(.LINES(LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .gap       (gap_cur),
   .start     (start_cur),
   .move_due  (move_due),
   .in_copy   (in_copy)
);

// File: tb/sg_wear_leveler_test.sv
`timescale 1ns/1ps
module sg_wear_leveler_test;
   localparam int LINES  = 8;
   localparam int PSI    = 5;
   localparam int DATA_W = 32;
   localparam int LA_W   = 3;
   localparam int PA_W   = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [LA_W-1:0]   req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_ready;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic              mem_en;
   logic              mem_we;
   logic [PA_W-1:0]   mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;

   logic [DATA_W-1:0] mem [0:LINES];
   logic [DATA_W-1:0] shadow [0:LINES-1];

   int checks = 0;
   int errors = 0;
   int exp_start = 0;
   int exp_gap = LINES;
   int wcount = 0;
   int wraps = 0;

   always #4 clk = ~clk;

   sg_wear_leveler #(.LINES(LINES), .PSI(PSI), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= LINES; i++) mem[i] <= '0;
         mem_rdata <= '0;
      end else if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_pa(input int la);
      int p;
      p = (la + exp_start) % LINES;
      if (p >= exp_gap) p++;
      return p;
   endfunction

   // Relocation: entered at the negedge after the PSI-th write was taken.
   task automatic check_move(input int held_la);
      int src;
      logic [DATA_W-1:0] moved;
      src = (exp_gap == 0) ? LINES : exp_gap - 1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = LA_W'(held_la);
      req_wdata = 32'hBAD0_0000 | held_la;
      #1;
      check(req_ready == 1'b0, "R6 ready low in move read", req_ready, 0);
      check(mem_en && !mem_we, "R5 move read enable", {mem_en, mem_we}, 2);
      check(mem_addr == src, "R5 move read address", mem_addr, src);
      moved = mem[src];
      @(negedge clk); #1;
      check(req_ready == 1'b0, "R6 ready low in move write", req_ready, 0);
      check(mem_en && mem_we, "R5 move write enable", {mem_en, mem_we}, 3);
      check(mem_addr == exp_gap, "R5 move write address", mem_addr, exp_gap);
      check(mem_wdata == moved, "R5 move write data", mem_wdata, moved);
      if (exp_gap == 0) begin
         exp_gap = LINES;
         exp_start = (exp_start + 1) % LINES;
         if (exp_start == 0) wraps++;
      end else begin
         exp_gap--;
      end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(req_ready == 1'b1, "R6 ready back after move", req_ready, 1);
   endtask

   task automatic do_write(input int la, input logic [DATA_W-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = LA_W'(la); req_wdata = d;
      #1;
      check(req_ready == 1'b1, "R4 no early move before write", req_ready, 1);
      check(mem_en && mem_we, "R2 write enables", {mem_en, mem_we}, 3);
      check(mem_addr == exp_pa(la), "R2 write mapping", mem_addr, exp_pa(la));
      check(mem_addr != exp_gap, "R3 write skips slot", mem_addr, exp_gap);
      check(mem_wdata == d, "R2 write data", mem_wdata, d);
      @(posedge clk);
      shadow[la] = d;
      wcount++;
      @(negedge clk);
      req_valid = 1'b0;
      if (wcount == PSI) begin
         wcount = 0;
         check_move((la + 3) % LINES);
      end else begin
         #1;
         check(rsp_valid == 1'b0, "R9 no response after write", rsp_valid, 0);
      end
   endtask

   task automatic do_read(input int la);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = LA_W'(la);
      #1;
      check(req_ready == 1'b1, "R4 read accepted with no move", req_ready, 1);
      check(mem_en && !mem_we, "R2 read enables", {mem_en, mem_we}, 2);
      check(mem_addr == exp_pa(la), "R2 read mapping", mem_addr, exp_pa(la));
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(rsp_valid == 1'b1, "R9 response valid", rsp_valid, 1);
      check(rsp_rdata == shadow[la], "R8 read data", rsp_rdata, shadow[la]);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      check(mem_en == 1'b0, "R1 idle memory port", mem_en, 0);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd5;
      #1;
      check(mem_addr == 5, "R1 identity mapping", mem_addr, 5);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic test_fill();
      for (int i = 0; i < LINES; i++) do_write(i, 32'h1000_0000 + i * 32'h11);
      for (int i = 0; i < LINES; i++) do_read(i);
   endtask

   task automatic test_reads_free();
      for (int i = 0; i < 3 * PSI; i++) do_read((i * 3) % LINES);
      while (wcount != 0 || exp_gap != LINES - 1) do_write(6, 32'h2000_0000 + exp_gap);
      for (int i = 0; i < LINES; i++) do_read(i);
   endtask

   task automatic test_rotations();
      int i = 0;
      while (wraps < 2) begin
         if (i % 4 == 0) do_write(0, 32'hC0DE_0000 + i);
         else            do_write((i * 3 + i / 7) % LINES, 32'h5A5A_0000 ^ (i * 32'h0101));
         if (i % 2 == 1) do_read((i * 5 + 1) % LINES);
         i++;
      end
      for (int k = 0; k < LINES; k++) do_read(k);
      check(exp_start == 0 && wraps == 2, "R7 two full rotations", wraps, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < LINES; i++) shadow[i] = '0;
      test_reset();
      test_fill();
      test_reads_free();
      test_rotations();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule